// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block decides when the gate of a synchronous rectifier switch in a flyback secondary is on. Three comparators on the switch's drain-source voltage have already been digitised. The first reports that the voltage is below the turn-on level, which is the most negative of the three levels. The second reports that the voltage is above the turn-off level, a small negative value. The third reports that the voltage is above a positive re-arm level. The block passes all three flags through a synchronizer. It then sequences the gate through an armed state, a conducting state and a post-conduction blanking state.

Two timers in the system clock domain keep ringing from upsetting the gate. The minimum-on timer masks the turn-off flag for a programmable number of cycles after the gate turns on. The blanking timer masks the turn-on flag for a fixed number of cycles after turn-off, so that residual body-diode current cannot start a new cycle. Blanking ends early when the drain goes clearly positive.

A supply-good flag, with its hysteresis already applied, and an enable input hold the block in lockout or sleep. In both states the gate stays low.

Top module: `sr_gate_seq`

## Requirements
- R1: While reset is asserted, `stateOut` is 0 (lockout) and `gateOn` is low.
- R2: When `supplyOk` is low at a clock edge, the next cycle shows `stateOut` = 0 and `gateOn` low, whatever the earlier state was.
- R3: When `supplyOk` is high and `enable` is low at a clock edge, the next cycle shows `stateOut` = 1 (sleep) with `gateOn` low. Comparator activity has no effect in this state.
- R4: From lockout or sleep, once `supplyOk` and `enable` are both high at an edge, the next cycle shows `stateOut` = 2 (armed).
- R5: In the armed state, a rising turn-on flag reaches the state machine through two synchronizer flops. If the flag is set before edge k, `stateOut` becomes 3 (conducting) after edge k+2 and not earlier.
- R6: Once conducting, the gate stays on for at least `minOnCount`+1 cycles, even if the turn-off flag is high the whole time. The value of `minOnCount` is taken on the edge that enters the conducting state.
- R7: After the minimum on-time, a synchronized turn-off flag ends conduction, and the next state is 4 (blanking).
- R8: Blanking lasts exactly BLANK_CYCLES cycles and then returns to the armed state. The turn-on flag has no effect while blanking.
- R9: A synchronized re-arm flag during blanking moves the block to the armed state on the next edge. If the flag is set before edge k, `stateOut` is 2 after edge k+2.
- R10: When the turn-off and re-arm flags arrive together after the minimum on-time, the block enters blanking first and reaches the armed state one cycle later.
- R11: The state codes are 0 lockout, 1 sleep, 2 armed, 3 conducting and 4 blanking. `gateOn` is high exactly when the state is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| onCmp | input | 1 | Drain-source voltage below the turn-on level |
| offCmp | input | 1 | Drain-source voltage above the turn-off level |
| rstCmp | input | 1 | Drain-source voltage above the positive re-arm level |
| supplyOk | input | 1 | Supply good, hysteresis already applied |
| enable | input | 1 | High to run, low to sleep |
| minOnCount | input | CNT_W | Minimum on-time, in cycles minus one |
| gateOn | output | 1 | Gate drive request |
| stateOut | output | 3 | Current sequencer state |

## Verification
The bench aims at the exact cycle counts: synchronizer latency, the minimum-on boundary and the full blanking length. A design with one synchronizer flop too many or too few, or an off-by-one in either timer, moves a transition by one cycle, and the directed checks sample at that exact cycle. The bench also drives turn-off and re-arm together. A design that processed the re-arm first would skip the blanking state, and one that dropped the re-arm would sit out the whole blanking time. Supply or enable loss during conduction must drop the gate on the next cycle. Sleep must ignore the turn-on flag.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;
  typedef enum logic [2:0] {
    ST_LOCK  = 3'd0,
    ST_SLEEP = 3'd1,
    ST_ARMED = 3'd2,
    ST_COND  = 3'd3,
    ST_BLANK = 3'd4
  } srState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadMinOn;
    logic loadBlank;
    logic clearTimers;
  } srStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic onHit;
    logic offHit;
    logic resetHit;
    logic minOnDone;
    logic blankDone;
  } srFlags_t;
endpackage

// File: rtl/sr_gate_dp.sv
module sr_gate_dp
  import sr_gate_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int BLANK_CYCLES = 2000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             onCmp,
  input  logic             offCmp,
  input  logic             rstCmp,
  input  logic [CNT_W-1:0] minOnCount,
  input  srStrobe_t        strobe,
  output srFlags_t         flags
);
  localparam int NCMP    = 3;
  localparam int BLANK_W = $clog2(BLANK_CYCLES + 1);
  localparam logic [BLANK_W-1:0] BLANK_LOAD = BLANK_W'(BLANK_CYCLES - 1);

  logic [NCMP-1:0] syncPipe [SYNC_STAGES];
  logic [CNT_W-1:0] minOnCnt;
  logic [BLANK_W-1:0] blankCnt;

  // comparator synchronizer chain: bit 0 turn-on, bit 1 turn-off, bit 2 re-arm
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncPipe[s] <= '0;
      end else if (s == 0) begin
        syncPipe[s] <= {rstCmp, offCmp, onCmp};
      end else begin
        syncPipe[s] <= syncPipe[(s == 0) ? 0 : s - 1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      minOnCnt <= '0;
    end else if (strobe.clearTimers) begin
      minOnCnt <= '0;
    end else if (strobe.loadMinOn) begin
      minOnCnt <= minOnCount;
    end else if (minOnCnt != '0) begin
      minOnCnt <= minOnCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blankCnt <= '0;
    end else if (strobe.clearTimers) begin
      blankCnt <= '0;
    end else if (strobe.loadBlank) begin
      blankCnt <= BLANK_LOAD;
    end else if (blankCnt != '0) begin
      blankCnt <= blankCnt - 1'b1;
    end
  end

  always_comb begin
    flags.onHit     = syncPipe[SYNC_STAGES-1][0];
    flags.offHit    = syncPipe[SYNC_STAGES-1][1];
    flags.resetHit  = syncPipe[SYNC_STAGES-1][2];
    flags.minOnDone = (minOnCnt == '0);
    flags.blankDone = (blankCnt == '0);
  end
endmodule

// File: rtl/sr_gate_ctl.sv
module sr_gate_ctl
  import sr_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      supplyOk,
  input  logic      enable,
  input  srFlags_t  flags,
  output srState_t  stateQ,
  output srStrobe_t strobe
);
  srState_t stateNext;

  always_comb begin
    stateNext = stateQ;
    strobe    = '0;
    if (!supplyOk) begin
      stateNext          = ST_LOCK;
      strobe.clearTimers = 1'b1;
    end else if (!enable) begin
      stateNext          = ST_SLEEP;
      strobe.clearTimers = 1'b1;
    end else begin
      unique case (stateQ)
        ST_LOCK, ST_SLEEP: stateNext = ST_ARMED;
        ST_ARMED: begin
          if (flags.onHit) begin
            stateNext        = ST_COND;
            strobe.loadMinOn = 1'b1;
          end
        end
        ST_COND: begin
          // turn-off flag is masked until the minimum on-time elapses
          if (flags.minOnDone && flags.offHit) begin
            stateNext        = ST_BLANK;
            strobe.loadBlank = 1'b1;
          end
        end
        ST_BLANK: begin
          if (flags.resetHit || flags.blankDone) stateNext = ST_ARMED;
        end
        default: stateNext = ST_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_LOCK;
    else       stateQ <= stateNext;
  end
endmodule

// File: rtl/sr_gate_seq.sv
module sr_gate_seq
  import sr_gate_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int BLANK_CYCLES = 2000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             onCmp,
  input  logic             offCmp,
  input  logic             rstCmp,
  input  logic             supplyOk,
  input  logic             enable,
  input  logic [CNT_W-1:0] minOnCount,
  output logic             gateOn,
  output logic [2:0]       stateOut
);
  srState_t  stateQ;
  srStrobe_t strobe;
  srFlags_t  flags;

  sr_gate_dp #(
    .CNT_W(CNT_W), .BLANK_CYCLES(BLANK_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .onCmp(onCmp), .offCmp(offCmp), .rstCmp(rstCmp),
    .minOnCount(minOnCount), .strobe(strobe), .flags(flags)
  );

  sr_gate_ctl u_ctl (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .enable(enable),
    .flags(flags), .stateQ(stateQ), .strobe(strobe)
  );

  assign gateOn   = (stateQ == ST_COND);
  assign stateOut = stateQ;
endmodule

// File: rtl/sr_gate_seq_chk.sv
module sr_gate_seq_chk #(
  parameter int CNT_W        = 8,
  parameter int BLANK_CYCLES = 2000
) (
  input logic             clk,
  input logic             rstN,
  input logic             supplyOk,
  input logic             enable,
  input logic [CNT_W-1:0] minOnCount,
  input logic             gateOn,
  input logic [2:0]       stateOut
);
  localparam int BL_W = $clog2(BLANK_CYCLES + 1) + 1;

  logic [CNT_W:0]   onLen;
  logic [CNT_W-1:0] latchedMin;
  logic [BL_W-1:0]  blankLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onLen <= '0; latchedMin <= '0; blankLen <= '0;
    end else begin
      if (stateOut != 3'd3) latchedMin <= minOnCount;
      if (stateOut == 3'd3) onLen <= (onLen == '1) ? onLen : onLen + 1'b1;
      else                  onLen <= '0;
      if (stateOut == 3'd4) blankLen <= (blankLen == '1) ? blankLen : blankLen + 1'b1;
      else                  blankLen <= '0;
    end
  end

  p_lock_r2: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> (stateOut == 3'd0 && !gateOn));

  p_sleep_r3: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && !enable) |=> (stateOut == 3'd1 && !gateOn));

  p_rise_from_armed_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |-> $past(stateOut) == 3'd2);

  p_min_on_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 3'd3 && {1'b0, latchedMin} > onLen) |=> stateOut != 3'd4);

  p_off_to_blank_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(gateOn) && $past(supplyOk) && $past(enable)) |-> stateOut == 3'd4);

  p_blank_no_on_r8: assert property (@(posedge clk) disable iff (!rstN)
    stateOut == 3'd4 |=> stateOut != 3'd3);

  p_blank_limit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 3'd4 && blankLen >= BL_W'(BLANK_CYCLES - 1)) |=> stateOut != 3'd4);

  p_state_legal_r11: assert property (@(posedge clk) disable iff (!rstN)
    stateOut <= 3'd4);
endmodule

bind sr_gate_seq sr_gate_seq_chk #(.CNT_W(CNT_W), .BLANK_CYCLES(BLANK_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .enable(enable),
  .minOnCount(minOnCount), .gateOn(gateOn), .stateOut(stateOut)
);

// File: tb/sr_gate_seq_tb.sv
`timescale 1ns/1ps
module sr_gate_seq_tb;
  localparam int CNT_W = 6;
  localparam int BL    = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic onCmp = 0, offCmp = 0, rstCmp = 0, supplyOk = 0, enable = 0;
  logic [CNT_W-1:0] minOnCount = '0;
  logic gateOn;
  logic [2:0] stateOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sr_gate_seq #(.CNT_W(CNT_W), .BLANK_CYCLES(BL), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .onCmp(onCmp), .offCmp(offCmp), .rstCmp(rstCmp),
    .supplyOk(supplyOk), .enable(enable), .minOnCount(minOnCount),
    .gateOn(gateOn), .stateOut(stateOut)
  );

  // requirement-level reference model
  logic [2:0] mState;
  logic [2:0] p1, p2;
  int mMin, mBlank;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 3'd0; p1 = '0; p2 = '0; mMin = 0; mBlank = 0;
    end else begin
      if (!supplyOk) mState = 3'd0;
      else if (!enable) mState = 3'd1;
      else begin
        case (mState)
          3'd0, 3'd1: mState = 3'd2;
          3'd2: if (p2[0]) begin mState = 3'd3; mMin = int'(minOnCount); end
          3'd3: begin
            if (mMin == 0 && p2[1]) begin mState = 3'd4; mBlank = BL - 1; end
            else if (mMin != 0) mMin--;
          end
          3'd4: begin
            if (p2[2] || mBlank == 0) mState = 3'd2;
            else mBlank--;
          end
          default: mState = 3'd0;
        endcase
      end
      p2 = p1;
      p1 = {rstCmp, offCmp, onCmp};
    end
  end

  function automatic string tagFor(logic [2:0] s);
    case (s)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(tagFor(mState), int'(stateOut), int'(mState));
      check("R11", int'(gateOn), int'(mState == 3'd3));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240607));
    tick(3);
    check("R1", int'(stateOut), 0);
    check("R1", int'(gateOn), 0);
    rstN = 1'b1;
    tick(1);
    check("R2", int'(stateOut), 0);
    supplyOk = 1; enable = 1;
    tick(1);
    check("R4", int'(stateOut), 2);

    // turn-on latency and minimum on-time with turn-off held high
    minOnCount = 6'd5; onCmp = 1; offCmp = 1;
    tick(2);
    check("R5", int'(stateOut), 2);
    tick(1);
    check("R5", int'(stateOut), 3);
    for (int i = 0; i < 5; i++) begin
      tick(1);
      check("R6", int'(gateOn), 1);
    end
    tick(1);
    check("R7", int'(stateOut), 4);
    // full blanking with turn-on held high
    for (int i = 0; i < BL - 1; i++) begin
      tick(1);
      check("R8", int'(stateOut), 4);
    end
    tick(1);
    check("R8", int'(stateOut), 2);
    onCmp = 0;
    tick(1);
    check("R5", int'(stateOut), 3);
    tick(6);
    check("R7", int'(stateOut), 4);

    // early re-arm
    rstCmp = 1;
    tick(2);
    check("R9", int'(stateOut), 4);
    tick(1);
    check("R9", int'(stateOut), 2);
    rstCmp = 0; offCmp = 0;

    // simultaneous turn-off and re-arm
    onCmp = 1;
    tick(3);
    check("R5", int'(stateOut), 3);
    onCmp = 0;
    tick(6);
    check("R6", int'(stateOut), 3);
    offCmp = 1; rstCmp = 1;
    tick(3);
    check("R10", int'(stateOut), 4);
    tick(1);
    check("R10", int'(stateOut), 2);
    offCmp = 0; rstCmp = 0;

    // supply loss during conduction, then sleep ignoring turn-on
    onCmp = 1;
    tick(3);
    check("R5", int'(stateOut), 3);
    supplyOk = 0;
    tick(1);
    check("R2", int'(stateOut), 0);
    check("R2", int'(gateOn), 0);
    tick(2);
    supplyOk = 1; enable = 0;
    tick(1);
    check("R3", int'(stateOut), 1);
    tick(3);
    check("R3", int'(gateOn), 0);
    enable = 1;
    tick(1);
    check("R4", int'(stateOut), 2);
    tick(1);
    check("R5", int'(stateOut), 3);

    // constrained random phase, checked against the model
    for (int i = 0; i < 6000; i++) begin
      supplyOk   = ($urandom % 150) != 0;
      enable     = ($urandom % 120) != 0;
      onCmp      = ($urandom % 4) == 0;
      offCmp     = ($urandom % 3) == 0;
      rstCmp     = ($urandom % 7) == 0;
      if (($urandom % 16) == 0) minOnCount = CNT_W'($urandom % 12);
      tick(1);
    end
    finishRun();
  end
endmodule